// File: doc/BRIEF.md
# Receive Descriptor Completion Engine

This block completes entries of a small circular ring of receive descriptors, one per incoming Ethernet frame. Each descriptor occupies four 32-bit words in storage held inside the block. A host-side port can write and read every word. Software sets the ring size in bytes and moves a tail index to hand descriptors to the block. The block keeps a head index. It owns the descriptors from head up to, but not including, tail.

For every frame reported on the frame input, the block does one of two things. If it owns a descriptor, it fills in that descriptor's length word and status word, with the done flag set, and advances the head. If it owns none, it drops the frame and counts it as missed. Payload movement, checksums and tag stripping are done elsewhere. The only tag-related output is a VLAN flag, copied from a strap input. A frame that ends in error is still completed with the done flag set. Software recycles that descriptor by moving the tail, as it does for any other descriptor.

Top module: `rxwb_engine`

## Requirements
- R1: After reset, head_idx, tail_idx and missed_cnt read 0 and every descriptor word reads 0. The descriptor count is 0, so every frame is dropped and counted until a ring size is written.
- R2: A write on cfg_len_we sets the descriptor count to cfg_len_bytes divided by 16, limited to N_DESC. The same write sets head_idx and tail_idx to 0. A frame offered in that cycle is counted as missed.
- R3: A write on tail_we takes effect only when tail_wdata is below the descriptor count. Any other value is ignored and tail_idx keeps its value.
- R4: A frame offered with frm_valid while head_idx differs from tail_idx is accepted into descriptor head_idx. Its word 2, at word address 4*slot+2, becomes {16'h0000, frm_len}, where frm_len includes the 4-byte FCS. The value is visible on host_rd_data after the second rising edge following the frame's cycle.
- R5: Word 3 of an accepted frame, at address 4*slot+3, is written as follows:
  - bit 0 (done) = 1 and bit 1 (end of packet) = 1;
  - bit 3 = vlan_strap;
  - frm_err[0] (CRC) goes to bit 8, frm_err[1] (symbol) to bit 9, frm_err[2] (sequence) to bit 10, frm_err[3] (carrier extension) to bit 12, and frm_err[4] (receive data) to bit 15;
  - every other bit is 0.
  A frame with errors is still written with done set.
- R6: Word 2 and word 3 of a descriptor are written in the same clock edge. Before that edge, the done flag and the new length are not visible.
- R7: Each accepted frame advances head_idx by one. After the last descriptor (descriptor count minus 1) it wraps to 0.
- R8: When head_idx equals tail_idx, a frame writes no descriptor and head_idx is unchanged. missed_cnt increments by one and holds at 2^CNT_W-1.
- R9: The engine never writes words 0 and 1 of a descriptor. The host port writes any word. When the host and the engine write the same word in the same edge, the engine's value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len_we | input | 1 | Ring size write strobe |
| cfg_len_bytes | input | 16 | Ring size in bytes (16 per descriptor) |
| tail_we | input | 1 | Tail index write strobe |
| tail_wdata | input | $clog2(N_DESC+1) | New tail index |
| host_we | input | 1 | Host descriptor-word write strobe |
| host_addr | input | $clog2(4*N_DESC) | Host write word address |
| host_wdata | input | 32 | Host write data |
| host_rd_addr | input | $clog2(4*N_DESC) | Host read word address |
| host_rd_data | output | 32 | Word at host_rd_addr (combinational) |
| frm_valid | input | 1 | One-cycle frame-complete pulse |
| frm_len | input | 16 | Frame length in bytes including FCS |
| frm_err | input | 5 | Error flags: CRC, symbol, sequence, carrier extension, receive data (bit 0 up) |
| vlan_strap | input | 1 | Value copied into the VLAN status flag |
| head_idx | output | $clog2(N_DESC) | Next descriptor the engine will fill |
| tail_idx | output | $clog2(N_DESC) | Current tail index |
| missed_cnt | output | CNT_W | Saturating count of dropped frames |

## Verification
The bench builds the block with N_DESC=4 and CNT_W=4. With N_DESC=4, a ring-size write of 200 bytes shows the limit of 4 descriptors. It also makes the full ring, the wrap from descriptor 3 to 0 and a tail write of 4 quick to reach. A later 32-byte ring exercises a two-entry wrap. The 4-bit counter lets missed_cnt reach its saturation value of 15 within a few dozen frames. The bench also times a host write to hit the same word as an engine write in the same edge.

// File: rtl/rxwb_pkg.sv
// Shared constants and word-packing helpers for the receive descriptor
// completion engine. Assumes four 32-bit words per descriptor.
package rxwb_pkg;

    localparam int WORDS_PER_DESC = 4;
    localparam int WORD_W         = 32;
    localparam int LEN_OFF        = 2;   // word holding the frame length
    localparam int STAT_OFF       = 3;   // word holding status and errors

    // Length word: checksum half left zero, length in the low half.
    function automatic logic [WORD_W-1:0] pack_len_word(input logic [15:0] len);
        return {16'h0000, len};
    endfunction

    // Status word: done, end of packet and VLAN flags in the low byte,
    // error flags in the next byte, upper half zero.
    function automatic logic [WORD_W-1:0] pack_stat_word(input logic [4:0] err,
                                                        input logic       vlan);
        logic [7:0] err_byte;
        logic [7:0] stat_byte;
        err_byte  = {err[4], 2'b00, err[3], 1'b0, err[2], err[1], err[0]};
        stat_byte = {4'b0000, vlan, 1'b0, 1'b1, 1'b1};
        return {16'h0000, err_byte, stat_byte};
    endfunction

endpackage

// File: rtl/rxwb_ring_mem.sv
// Descriptor storage as a flop array with two write sources.
// The engine writes the length and status words of one slot per cycle.
// The host port writes any single word. On an address clash the engine
// value is kept. Reads are combinational.
// Assumes N_DESC >= 2.
module rxwb_ring_mem #(
    parameter int N_DESC = 8,
    localparam int IW = $clog2(N_DESC),
    localparam int NW = N_DESC * rxwb_pkg::WORDS_PER_DESC,
    localparam int AW = $clog2(NW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_slot,
    input  logic [31:0]   eng_w2,
    input  logic [31:0]   eng_w3,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [31:0]   host_wdata,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);

    logic [31:0] words [NW];

    for (genvar g = 0; g < NW; g++) begin : g_word
        localparam logic [IW-1:0] SLOT = IW'(g / rxwb_pkg::WORDS_PER_DESC);
        localparam int            OFF  = g % rxwb_pkg::WORDS_PER_DESC;
        localparam bit            ENG_OWNED = (OFF == rxwb_pkg::LEN_OFF) ||
                                              (OFF == rxwb_pkg::STAT_OFF);
        logic        eng_hit;
        logic        host_hit;
        logic [31:0] eng_val;

        assign eng_hit  = ENG_OWNED && eng_we && (eng_slot == SLOT);
        assign host_hit = host_we && (host_addr == AW'(g));
        assign eng_val  = (OFF == rxwb_pkg::STAT_OFF) ? eng_w3 : eng_w2;

        // Storage word update: reset clear, engine first, then host.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else if (eng_hit) begin
                words[g] <= eng_val;
            end else if (host_hit) begin
                words[g] <= host_wdata;
            end
        end
    end

    // Host read mux.
    always_comb begin
        rd_data = words[rd_addr];
    end

endmodule

// File: rtl/rxwb_ptr_ctrl.sv
// Ring pointer control: descriptor count, head and tail indices, the
// accept/drop decision for each frame, and the saturating missed counter.
// Assumes one frame pulse at most per cycle.
// Owned descriptors run from head up to, but not including, tail.
module rxwb_ptr_ctrl #(
    parameter int N_DESC = 8,
    parameter int CNT_W  = 16,
    localparam int IW = $clog2(N_DESC),
    localparam int CW = $clog2(N_DESC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_len_we,
    input  logic [15:0]      cfg_len_bytes,
    input  logic             tail_we,
    input  logic [CW-1:0]    tail_wdata,
    input  logic             frm_valid,
    output logic             accept,
    output logic [IW-1:0]    head,
    output logic [IW-1:0]    tail,
    output logic [CW-1:0]    desc_cnt,
    output logic [CNT_W-1:0] missed
);

    logic [11:0]   raw_cnt;
    logic [CW-1:0] cnt_next;
    logic [CW:0]   head_inc;
    logic          head_wrap;
    logic [IW-1:0] head_next;
    logic          tail_ok;
    logic          sat;

    // Count from the byte length, limited to the storage size.
    always_comb begin
        raw_cnt  = cfg_len_bytes[15:4];
        cnt_next = (raw_cnt > 12'(N_DESC)) ? CW'(N_DESC) : raw_cnt[CW-1:0];
    end

    // Accept decision, head successor with wrap, and tail range check.
    always_comb begin
        accept    = frm_valid && !cfg_len_we && (head != tail);
        head_inc  = {1'b0, CW'(head)} + (CW+1)'(1);
        head_wrap = (head_inc == {1'b0, desc_cnt});
        head_next = head_wrap ? '0 : head + IW'(1);
        tail_ok   = tail_we && (tail_wdata < desc_cnt);
        sat       = (missed == {CNT_W{1'b1}});
    end

    // Descriptor count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_cnt <= '0;
        end else if (cfg_len_we) begin
            desc_cnt <= cnt_next;
        end
    end

    // Head index: cleared by a ring size write, stepped per accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (cfg_len_we) begin
            head <= '0;
        end else if (accept) begin
            head <= head_next;
        end
    end

    // Tail index: cleared by a ring size write, loaded by an in-range write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (cfg_len_we) begin
            tail <= '0;
        end else if (tail_ok) begin
            tail <= tail_wdata[IW-1:0];
        end
    end

    // Missed-frame counter, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            missed <= '0;
        end else if (frm_valid && !accept && !sat) begin
            missed <= missed + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rxwb_wb_stage.sv
// Writeback stage. It registers the target slot and both packed
// descriptor words of an accepted frame. It presents them to storage one
// cycle later as a single write of both words, so done never leads the
// length. Assumes the accept decision has already been made.
module rxwb_wb_stage #(
    parameter int N_DESC = 8,
    localparam int IW = $clog2(N_DESC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [IW-1:0] slot_in,
    input  logic [15:0]   frm_len,
    input  logic [4:0]    frm_err,
    input  logic          vlan_strap,
    output logic          eng_we,
    output logic [IW-1:0] eng_slot,
    output logic [31:0]   eng_w2,
    output logic [31:0]   eng_w3
);

    import rxwb_pkg::*;

    // Pending-write valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_we <= 1'b0;
        end else begin
            eng_we <= accept;
        end
    end

    // Capture of slot and packed words for the accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_slot <= '0;
            eng_w2   <= '0;
            eng_w3   <= '0;
        end else if (accept) begin
            eng_slot <= slot_in;
            eng_w2   <= pack_len_word(frm_len);
            eng_w3   <= pack_stat_word(frm_err, vlan_strap);
        end
    end

endmodule

// File: rtl/rxwb_engine.sv
// Receive descriptor completion engine, top level. For each reported
// frame it either fills the descriptor at head and advances head, or
// drops the frame and counts it when the ring holds no owned entry.
// Assumes N_DESC >= 2 and frames arrive as one-cycle pulses.
module rxwb_engine #(
    parameter int N_DESC = 8,
    parameter int CNT_W  = 16,
    localparam int IW = $clog2(N_DESC),
    localparam int CW = $clog2(N_DESC + 1),
    localparam int AW = $clog2(N_DESC * rxwb_pkg::WORDS_PER_DESC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_len_we,
    input  logic [15:0]      cfg_len_bytes,
    input  logic             tail_we,
    input  logic [CW-1:0]    tail_wdata,
    input  logic             host_we,
    input  logic [AW-1:0]    host_addr,
    input  logic [31:0]      host_wdata,
    input  logic [AW-1:0]    host_rd_addr,
    output logic [31:0]      host_rd_data,
    input  logic             frm_valid,
    input  logic [15:0]      frm_len,
    input  logic [4:0]       frm_err,
    input  logic             vlan_strap,
    output logic [IW-1:0]    head_idx,
    output logic [IW-1:0]    tail_idx,
    output logic [CNT_W-1:0] missed_cnt
);

    logic          accept;
    logic [CW-1:0] desc_cnt;
    logic          eng_we;
    logic [IW-1:0] eng_slot;
    logic [31:0]   eng_w2;
    logic [31:0]   eng_w3;

    rxwb_ptr_ctrl #(.N_DESC(N_DESC), .CNT_W(CNT_W)) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_len_we    (cfg_len_we),
        .cfg_len_bytes (cfg_len_bytes),
        .tail_we       (tail_we),
        .tail_wdata    (tail_wdata),
        .frm_valid     (frm_valid),
        .accept        (accept),
        .head          (head_idx),
        .tail          (tail_idx),
        .desc_cnt      (desc_cnt),
        .missed        (missed_cnt)
    );

    rxwb_wb_stage #(.N_DESC(N_DESC)) u_wb (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .slot_in    (head_idx),
        .frm_len    (frm_len),
        .frm_err    (frm_err),
        .vlan_strap (vlan_strap),
        .eng_we     (eng_we),
        .eng_slot   (eng_slot),
        .eng_w2     (eng_w2),
        .eng_w3     (eng_w3)
    );

    rxwb_ring_mem #(.N_DESC(N_DESC)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_we     (eng_we),
        .eng_slot   (eng_slot),
        .eng_w2     (eng_w2),
        .eng_w3     (eng_w3),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .rd_addr    (host_rd_addr),
        .rd_data    (host_rd_data)
    );

endmodule

// File: rtl/rxwb_checker.sv
// Property checker for the receive descriptor completion engine.
// It is attached to every instance of the top module by the bind below.
module rxwb_checker #(
    parameter int N_DESC = 8,
    parameter int CNT_W  = 16,
    localparam int IW = $clog2(N_DESC),
    localparam int CW = $clog2(N_DESC + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frm_valid,
    input logic             cfg_len_we,
    input logic             accept,
    input logic [IW-1:0]    head_idx,
    input logic [IW-1:0]    tail_idx,
    input logic [CW-1:0]    desc_cnt,
    input logic [CNT_W-1:0] missed_cnt,
    input logic             eng_we,
    input logic [IW-1:0]    eng_slot
);

    localparam logic [CNT_W-1:0] MISS_MAX = {CNT_W{1'b1}};

    AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_cnt == '0 && head_idx == '0) || (CW'(head_idx) < desc_cnt)); // R7

    AST_TAIL_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_cnt == '0 && tail_idx == '0) || (CW'(tail_idx) < desc_cnt)); // R3

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_len_we |=> (head_idx == '0 && tail_idx == '0)); // R2

    AST_FULL_HOLDS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !cfg_len_we && head_idx == tail_idx) |=> (head_idx == $past(head_idx))); // R8

    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (cfg_len_we || head_idx == tail_idx) && missed_cnt != MISS_MAX)
        |=> (missed_cnt == $past(missed_cnt) + CNT_W'(1))); // R8

    AST_MISS_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (missed_cnt == MISS_MAX) |=> (missed_cnt == MISS_MAX)); // R8

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (CW'(head_idx) + CW'(1) == desc_cnt)) |=> (head_idx == '0)); // R7

    AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (eng_we && eng_slot == $past(head_idx))); // R4

endmodule

bind rxwb_engine rxwb_checker #(.N_DESC(N_DESC), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .cfg_len_we (cfg_len_we),
    .accept     (accept),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .desc_cnt   (desc_cnt),
    .missed_cnt (missed_cnt),
    .eng_we     (eng_we),
    .eng_slot   (eng_slot)
);

// File: tb/sim_rxwb_engine.sv
`timescale 1ns/100ps
module sim_rxwb_engine;

    localparam int N  = 4;
    localparam int CNTW = 4;
    localparam int IW = $clog2(N);
    localparam int CW = $clog2(N + 1);
    localparam int AW = $clog2(N * 4);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_len_we = 1'b0;
    logic [15:0]     cfg_len_bytes = '0;
    logic            tail_we = 1'b0;
    logic [CW-1:0]   tail_wdata = '0;
    logic            host_we = 1'b0;
    logic [AW-1:0]   host_addr = '0;
    logic [31:0]     host_wdata = '0;
    logic [AW-1:0]   host_rd_addr = '0;
    logic [31:0]     host_rd_data;
    logic            frm_valid = 1'b0;
    logic [15:0]     frm_len = '0;
    logic [4:0]      frm_err = '0;
    logic            vlan_strap = 1'b0;
    logic [IW-1:0]   head_idx;
    logic [IW-1:0]   tail_idx;
    logic [CNTW-1:0] missed_cnt;

    rxwb_engine #(.N_DESC(N), .CNT_W(CNTW)) u0 (.*);

    always #2 clk = ~clk;

    typedef struct {
        int          slot;
        logic [31:0] w2;
        logic [31:0] w3;
        int          due;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;

    int m_head = 0, m_tail = 0, m_cnt = 0, m_missed = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        host_rd_addr = AW'(addr);
        #0.3;
        d = host_rd_data;
    endtask

    // Monitor: pops scoreboard items once their write edge has passed.
    always @(negedge clk) begin
        if (sb.size() > 0 && cyc >= sb[0].due) begin
            item_t it;
            logic [31:0] d;
            it = sb.pop_front();
            host_rd_addr = AW'(it.slot * 4 + 2);
            #0.2;
            d = host_rd_data;
            chk("R4 length word", d, it.w2);
            host_rd_addr = AW'(it.slot * 4 + 3);
            #0.2;
            d = host_rd_data;
            chk("R5 status word", d, it.w3);
        end
    end

    // Driver: offers one frame and pushes the expected result.
    task automatic send_frame(input logic [15:0] len, input logic [4:0] err, input logic vl);
        frm_valid = 1'b1; frm_len = len; frm_err = err; vlan_strap = vl;
        if (m_head != m_tail) begin
            item_t it;
            it.slot = m_head;
            it.w2 = {16'h0, len};
            it.w3 = 32'h3 | (32'(vl) << 3) | (32'(err[0]) << 8) | (32'(err[1]) << 9)
                  | (32'(err[2]) << 10) | (32'(err[3]) << 12) | (32'(err[4]) << 15);
            it.due = cyc + 2;
            sb.push_back(it);
            m_head = (m_head + 1 == m_cnt) ? 0 : m_head + 1;
        end else if (m_missed < 15) begin
            m_missed++;
        end
        @(negedge clk);
        frm_valid = 1'b0; frm_err = '0; vlan_strap = 1'b0;
    endtask

    task automatic set_len(input int bytes);
        cfg_len_we = 1'b1; cfg_len_bytes = 16'(bytes);
        m_cnt = (bytes / 16 > N) ? N : bytes / 16;
        m_head = 0; m_tail = 0;
        @(negedge clk);
        cfg_len_we = 1'b0;
    endtask

    task automatic set_tail(input int t);
        tail_we = 1'b1; tail_wdata = CW'(t);
        if (t < m_cnt) m_tail = t;
        @(negedge clk);
        tail_we = 1'b0;
    endtask

    task automatic host_wr(input int addr, input logic [31:0] d);
        host_we = 1'b1; host_addr = AW'(addr); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        chk("R1 head after reset", 32'(head_idx), 0);
        chk("R1 tail after reset", 32'(tail_idx), 0);
        chk("R1 missed after reset", 32'(missed_cnt), 0);
        rd(2, d); chk("R1 word clear after reset", d, 0);

        send_frame(16'd64, 5'b0, 1'b0);
        chk("R1 frame dropped with no ring", 32'(missed_cnt), 32'(m_missed));

        host_wr(0, 32'h1234_5678);
        host_wr(5, 32'hCAFE_F00D);

        set_len(64);
        chk("R2 head after ring size", 32'(head_idx), 0);
        set_tail(3);
        chk("R3 tail in range", 32'(tail_idx), 3);

        send_frame(16'd64, 5'b00000, 1'b0);
        rd(3, d); chk("R6 done not early", d, 0);
        rd(2, d); chk("R6 length not early", d, 0);
        send_frame(16'd1518, 5'b00001, 1'b1);
        send_frame(16'd100, 5'b11110, 1'b0);
        drain();
        chk("R7 head after three frames", 32'(head_idx), 3);

        send_frame(16'd80, 5'b0, 1'b0);
        drain();
        chk("R8 missed on full ring", 32'(missed_cnt), 32'(m_missed));
        chk("R8 head held on full ring", 32'(head_idx), 3);
        rd(15, d); chk("R8 no write on full ring", d, 0);

        set_tail(5);
        chk("R3 out-of-range tail ignored", 32'(tail_idx), 3);

        set_tail(1);
        send_frame(16'd72, 5'b10000, 1'b1);
        send_frame(16'd90, 5'b00100, 1'b0);
        drain();
        chk("R7 head wrapped past last", 32'(head_idx), 1);
        rd(0, d); chk("R9 word 0 untouched", d, 32'h1234_5678);

        set_tail(2);
        send_frame(16'd256, 5'b01000, 1'b0);
        host_wr(6, 32'hDEAD_BEEF);
        drain();
        rd(5, d); chk("R9 word 1 untouched", d, 32'hCAFE_F00D);

        set_len(200);
        chk("R2 head cleared", 32'(head_idx), 0);
        chk("R2 tail cleared", 32'(tail_idx), 0);
        set_tail(4);
        chk("R3 tail equal to count ignored", 32'(tail_idx), 0);
        set_tail(3);
        chk("R2 count limited to four", 32'(tail_idx), 3);

        set_len(32);
        set_tail(1);
        send_frame(16'd60, 5'b0, 1'b1);
        set_tail(0);
        send_frame(16'd61, 5'b00010, 1'b0);
        drain();
        chk("R7 two-entry wrap", 32'(head_idx), 0);

        for (int i = 0; i < 16; i++) send_frame(16'd64, 5'b0, 1'b0);
        drain();
        chk("R8 missed saturates", 32'(missed_cnt), 15);
        chk("R8 model saturates", 32'(m_missed), 15);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule